// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a clocked static RAM with registered inputs and a registered read path. The default is 1K words of 18 bits, split into two 9-bit lanes. All control inputs are sampled on the rising clock edge. A new burst begins when either of two active-low address strobes loads the address register. After that, an active-low advance input steps a 2-bit counter through the four words of an aligned block, in linear or interleaved order.

Writes either cover the whole word, through the global write input, or select lanes one at a time, through the lane enables and their gate. The read data for a cycle's address appears on `dout` after the following clock edge. `dout_valid` stands in for the output drivers of a tristate bus. A sleep input freezes every state element and leaves the stored data intact.

Top module: `burst_sram`

## Requirements
- R1: An address is loaded when `ctrl_stb_n` is low, whatever `en_n` is. An address is also loaded when `proc_stb_n` and `en_n` are both low. `proc_stb_n` low with `en_n` high changes nothing. When both strobes are low, the load follows the `ctrl_stb_n` rules, so the chip is selected only if `en_n` is low.
- R2: A load selects the chip only if `en_n` is 0, `sel_hi` is 1 and `sel_lo_n` is 0. A deselected chip performs no writes, and `dout_valid` stays low for its cycles.
- R3: The cycle address is the base address with its two low bits replaced by an offset built from a 2-bit count. A load clears the count to 0. The count rises by 1 (modulo 4) in each selected cycle without a load that has `burst_step_n` low, and holds while `burst_step_n` is high.
- R4: With `order_ilv`=0 the offset is (start + count) mod 4, where start is bits [1:0] of the loaded address.
- R5: With `order_ilv`=1 the offset is start XOR count. `order_ilv` changes only while no burst is running.
- R6: `all_wr_n` low writes both lanes from `din`. It takes precedence over `lane_gate_n` and `lane_wr_n`.
- R7: `lane_wr_n` bits take effect only when `lane_gate_n` is low. Bit 0 (low = write) writes `din[8:0]` and bit 1 writes `din[17:9]`. A cycle with neither write path open is a read.
- R8: Read data for the address registered at edge k is on `dout`, with `dout_valid` high, after edge k+1.
- R9: While the cycle registered at the latest edge is a selected write, `dout_valid` is low.
- R10: `out_en_n` high forces `dout_valid` low without waiting for a clock edge.
- R11: With `sleep` high at an edge, no register and no memory word changes: the counter, the selection, `dout` and the stored data all hold.
- R12: During reset the chip is deselected and `dout_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Word address |
| proc_stb_n | input | 1 | Processor address strobe, active low, gated by `en_n` |
| ctrl_stb_n | input | 1 | Controller address strobe, active low, not gated |
| burst_step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_gate_n | input | 1 | Lets the lane enables through when low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| en_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| sleep | input | 1 | Freezes all state when high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_valid | output | 1 | Stands in for the enabled output drivers |

## Verification
A read and a write can fall in consecutive edges. The read's data then reaches the output register in the same cycle that the write is registered, so the output blanking and the read pipeline collide. The bench provokes this by placing full-word and lane writes directly after read cycles. The scoreboard expects `dout_valid` low in that window, because the stage holding the write is known when the read result is compared. It also expects the write to be visible to the next read. Sleep cycles are placed in the middle of a burst together with write and load attempts, so that the freeze and the write path also share cycles.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int unsigned BURST_W = 2;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_ord_e;

  function automatic logic [BURST_W-1:0] burst_offset(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input burst_ord_e         ord
  );
    if (ord == ORD_XOR) return start ^ step;
    return start + step;
  endfunction
endpackage

// File: rtl/bsr_front.sv
module bsr_front #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce,
  input  logic                      ctrl_stb_n,
  input  logic                      proc_stb_n,
  input  logic                      en_n,
  input  logic                      sel_hi,
  input  logic                      sel_lo_n,
  input  logic                      all_wr_n,
  input  logic                      lane_gate_n,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic [ADDR_W-1:0]         addr_in,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic                      load,
  output logic [ADDR_W-1:0]         base_q,
  output logic                      on_q,
  output logic [LANES-1:0]          wmask_q,
  output logic [LANES*LANE_W-1:0]   din_q
);
  logic                    sel_now;
  logic [ADDR_W-1:0]       base_d;
  logic                    on_d;
  logic [LANES-1:0]        wmask_d;

  always_comb begin
    load    = !ctrl_stb_n || (!proc_stb_n && !en_n);
    sel_now = !en_n && sel_hi && !sel_lo_n;
    base_d  = load ? addr_in : base_q;
    on_d    = load ? sel_now : on_q;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_mask
    assign wmask_d[g] = !all_wr_n || (!lane_gate_n && !lane_wr_n[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      on_q    <= 1'b0;
      wmask_q <= '0;
      din_q   <= '0;
    end else if (ce) begin
      base_q  <= base_d;
      on_q    <= on_d;
      wmask_q <= wmask_d;
      din_q   <= din;
    end
  end

  // R1: processor strobe without chip enable loads nothing
  p_proc_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && ctrl_stb_n && en_n) |=> ($stable(base_q) && $stable(on_q)));

  // R2: a load with any select term false leaves the chip deselected
  p_sel_terms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && load && !(!en_n && sel_hi && !sel_lo_n)) |=> !on_q);

  // R6: global write opens every lane
  p_gw_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !all_wr_n) |=> (&wmask_q));

  // R7: closed gate and no global write means no lane is written
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && all_wr_n && lane_gate_n) |=> (wmask_q == '0));

  // R11: frozen front stage while sleeping
  p_sleep_front_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(base_q) && $stable(on_q) && $stable(wmask_q)));
endmodule

// File: rtl/bsr_burst.sv
module bsr_burst
  import bsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic               load,
  input  logic               step,
  input  burst_ord_e         ord,
  input  logic [BURST_W-1:0] start,
  output logic [BURST_W-1:0] off
);
  localparam int unsigned CNT_W = BURST_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (load)      cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
    off = burst_offset(start, cnt_q, ord);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (ce) cnt_q <= cnt_d;
  end

  // R3: a load restarts the count
  p_load_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && load) |=> (cnt_q == '0));

  // R3: advance steps by one, wrapping in the block of four
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !load && step) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R3: no advance, no movement
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !load && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic                    on_q,
  input  logic [LANES-1:0]        wmask_q,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din_q,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_v
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic rd_v_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_lane_q;
    logic              we;

    assign we = on_q && wmask_q[g];

    always_ff @(posedge clk) begin
      if (ce) begin
        if (we) mem[addr] <= din_q[g*LANE_W +: LANE_W];
        rd_lane_q <= mem[addr];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_lane_q;
  end

  always_comb rd_v_d = on_q && (wmask_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_v <= 1'b0;
    else if (ce) rd_v <= rd_v_d;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    proc_stb_n,
  input  logic                    ctrl_stb_n,
  input  logic                    burst_step_n,
  input  logic                    all_wr_n,
  input  logic                    lane_gate_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    en_n,
  input  logic                    sel_hi,
  input  logic                    sel_lo_n,
  input  logic                    out_en_n,
  input  logic                    order_ilv,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_valid
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic               rst_meta_q;
  logic               rst_sync_q;
  logic               ce;
  logic               load;
  logic [ADDR_W-1:0]  base_q;
  logic               on_q;
  logic [LANES-1:0]   wmask_q;
  logic [DATA_W-1:0]  din_q;
  logic [BURST_W-1:0] off;
  logic [ADDR_W-1:0]  mem_addr;
  logic               rd_v;
  logic               wr_now;
  logic               step;
  burst_ord_e         ord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    ce       = !sleep;
    ord      = burst_ord_e'(order_ilv);
    step     = !burst_step_n && on_q;
    mem_addr = {base_q[ADDR_W-1:BURST_W], off};
    wr_now   = on_q && (wmask_q != '0);
    dout_valid = rd_v && !out_en_n && !wr_now;
  end

  bsr_front #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_front (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .ce          (ce),
    .ctrl_stb_n  (ctrl_stb_n),
    .proc_stb_n  (proc_stb_n),
    .en_n        (en_n),
    .sel_hi      (sel_hi),
    .sel_lo_n    (sel_lo_n),
    .all_wr_n    (all_wr_n),
    .lane_gate_n (lane_gate_n),
    .lane_wr_n   (lane_wr_n),
    .addr_in     (addr),
    .din         (din),
    .load        (load),
    .base_q      (base_q),
    .on_q        (on_q),
    .wmask_q     (wmask_q),
    .din_q       (din_q)
  );

  bsr_burst u_burst (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .ce    (ce),
    .load  (load),
    .step  (step),
    .ord   (ord),
    .start (base_q[BURST_W-1:0]),
    .off   (off)
  );

  bsr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .ce      (ce),
    .on_q    (on_q),
    .wmask_q (wmask_q),
    .addr    (mem_addr),
    .din_q   (din_q),
    .rd_data (dout),
    .rd_v    (rd_v)
  );

  // R9: a selected full write registered at an edge blanks the output after it
  p_blank_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!sleep && !all_wr_n && !ctrl_stb_n && !en_n && sel_hi && !sel_lo_n)
      |=> !dout_valid);

  // R2: deselection reaches the output one pipeline stage later
  p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!sleep && !ctrl_stb_n && !sel_hi) ##1 !sleep |=> !dout_valid);

  // R11: read register holds while sleeping
  p_sleep_out_r11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    sleep |=> ($stable(dout) && $stable(rd_v)));
endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DW = NL * LW;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          proc_stb_n, ctrl_stb_n, burst_step_n, all_wr_n, lane_gate_n;
  logic [NL-1:0] lane_wr_n;
  logic          en_n, sel_hi, sel_lo_n, out_en_n, order_ilv, sleep;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_valid;

  burst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n), .burst_step_n(burst_step_n), .all_wr_n(all_wr_n),
    .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n), .en_n(en_n),
    .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .out_en_n(out_en_n),
    .order_ilv(order_ilv), .sleep(sleep), .din(din), .dout(dout),
    .dout_valid(dout_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit            hold;
    bit            rd;
    bit            wr;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t          q[$];
  int            n_chk = 0;
  int            n_fail = 0;
  bit            run = 0;
  logic [DW-1:0] m_mem [0:(1<<AW)-1];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  bit            m_on = 0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle, updates the reference model, queues the expectation
  task automatic cyc(input bit c_n, input bit p_n, input bit v_n, input bit e_n,
                     input bit s0, input bit s1n, input bit g_n, input bit be_n,
                     input logic [NL-1:0] b_n, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input bit o_n, input bit z,
                     input string tag);
    exp_t          it;
    bit            ld;
    logic [1:0]    off;
    logic [AW-1:0] ca;
    logic [NL-1:0] msk;
    ctrl_stb_n = c_n; proc_stb_n = p_n; burst_step_n = v_n; en_n = e_n;
    sel_hi = s0; sel_lo_n = s1n; all_wr_n = g_n; lane_gate_n = be_n;
    lane_wr_n = b_n; addr = a; din = d; out_en_n = o_n; sleep = z;
    it.hold = z; it.rd = 0; it.wr = 0; it.data = '0; it.tag = tag;
    if (!z) begin
      ld = !c_n || (!p_n && !e_n);
      if (ld) begin
        m_base = a; m_cnt = '0; m_on = !e_n && s0 && !s1n;
      end else if (!v_n && m_on) begin
        m_cnt = m_cnt + 2'd1;
      end
      off = order_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      ca  = {m_base[AW-1:2], off};
      msk = !g_n ? '1 : (!be_n ? ~b_n : '0);
      it.rd = m_on && (msk == '0);
      it.wr = m_on && (msk != '0);
      it.data = m_mem[ca];
      if (it.wr)
        for (int l = 0; l < NL; l++)
          if (msk[l]) m_mem[ca][l*LW +: LW] = d[l*LW +: LW];
    end
    @(posedge clk);
    q.push_back(it);
    #1;
  endtask

  task automatic rd_ld(input logic [AW-1:0] a, input string tag);
    cyc(0, 1, 1, 0, 1, 0, 1, 1, '1, a, '0, 0, 0, tag);
  endtask
  task automatic rd_adv(input string tag);
    cyc(1, 1, 0, 0, 1, 0, 1, 1, '1, '0, '0, 0, 0, tag);
  endtask
  task automatic rd_hold(input string tag);
    cyc(1, 1, 1, 0, 1, 0, 1, 1, '1, '0, '0, 0, 0, tag);
  endtask
  task automatic wr_ld(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    cyc(0, 1, 1, 0, 1, 0, 0, 1, '1, a, d, 0, 0, tag);
  endtask
  task automatic wr_adv(input logic [DW-1:0] d, input string tag);
    cyc(1, 1, 0, 0, 1, 0, 0, 1, '1, '0, d, 0, 0, tag);
  endtask

  // Monitor: tracks the item in the output register and the item in the input stage
  exp_t shown, staged;
  bit   have_shown = 0;
  bit   have_staged = 0;
  always @(negedge clk) begin
    if (run && q.size() > 0) begin
      exp_t cur;
      bit   ev;
      cur = q.pop_front();
      if (!cur.hold) begin
        shown = staged; have_shown = have_staged;
        staged = cur; have_staged = 1;
      end
      if (have_shown) begin
        ev = shown.rd && !staged.wr && !out_en_n;
        chk(dout_valid == ev, {shown.tag, "/", staged.tag, " valid"},
            {{(DW-1){1'b0}}, dout_valid}, {{(DW-1){1'b0}}, ev});
        if (ev) chk(dout === shown.data, {shown.tag, "/", staged.tag, " data"},
                    dout, shown.data);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; addr = '0; proc_stb_n = 1; ctrl_stb_n = 1; burst_step_n = 1;
    all_wr_n = 1; lane_gate_n = 1; lane_wr_n = '1; en_n = 1; sel_hi = 0;
    sel_lo_n = 1; out_en_n = 0; order_ilv = 0; sleep = 0; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dout_valid == 1'b0, "R12 reset", {{(DW-1){1'b0}}, dout_valid}, '0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    run = 1;

    // R6 full-word burst write, linear order from offset 0
    wr_ld(10'h010, 18'h01234, "R6");
    wr_adv(18'h0ABCD, "R6");
    wr_adv(18'h15A5A, "R6");
    wr_adv(18'h3C3C3, "R6");
    rd_hold("R8");
    // R4 linear burst from offset 2 with wrap (R3)
    rd_ld(10'h012, "R4");
    rd_adv("R4");
    rd_adv("R3");
    rd_adv("R4");
    rd_hold("R3");
    rd_hold("R3");
    rd_ld(10'h013, "R8");
    // R7 lane writes and the closed gate
    wr_ld(10'h020, 18'h3FFFF, "R9");
    cyc(1, 1, 1, 0, 1, 0, 1, 0, 2'b10, '0, 18'h00000, 0, 0, "R7");
    cyc(1, 1, 1, 0, 1, 0, 1, 1, 2'b00, '0, 18'h00000, 0, 0, "R7");
    rd_hold("R7");
    cyc(1, 1, 1, 0, 1, 0, 1, 0, 2'b01, '0, 18'h2AAAA, 0, 0, "R7");
    rd_hold("R7");
    cyc(1, 1, 1, 0, 1, 0, 0, 0, 2'b11, '0, 18'h15555, 0, 0, "R6");
    rd_hold("R6");
    rd_hold("R6");
    // R9 read directly followed by a write
    rd_hold("R9");
    cyc(1, 1, 1, 0, 1, 0, 0, 1, '1, '0, 18'h0F0F0, 0, 0, "R9");
    rd_hold("R9");
    rd_hold("R9");
    // R1 strobe gating and priority
    rd_ld(10'h011, "R1");
    cyc(1, 0, 1, 1, 1, 0, 1, 1, '1, 10'h030, '0, 0, 0, "R1");
    rd_hold("R1");
    cyc(0, 0, 1, 1, 1, 0, 1, 1, '1, 10'h012, '0, 0, 0, "R1");
    rd_hold("R1");
    cyc(1, 0, 1, 0, 1, 0, 1, 1, '1, 10'h013, '0, 0, 0, "R1");
    rd_adv("R1");
    // R2 deselected loads and blocked writes
    cyc(0, 1, 1, 0, 0, 0, 0, 1, '1, 10'h010, 18'h00000, 0, 0, "R2");
    cyc(1, 1, 0, 0, 1, 0, 0, 1, '1, '0, 18'h00000, 0, 0, "R2");
    cyc(0, 1, 1, 0, 1, 1, 1, 1, '1, 10'h011, '0, 0, 0, "R2");
    rd_ld(10'h010, "R2");
    rd_adv("R2");
    // R11 sleep in mid-burst with write and load attempts
    rd_ld(10'h010, "R11");
    rd_adv("R11");
    cyc(1, 1, 0, 0, 1, 0, 0, 1, '1, '0, 18'h00000, 0, 1, "R11");
    cyc(1, 1, 0, 0, 1, 0, 0, 1, '1, '0, 18'h00000, 0, 1, "R11");
    cyc(0, 1, 1, 0, 1, 0, 1, 1, '1, 10'h020, '0, 0, 1, "R11");
    rd_adv("R11");
    rd_adv("R11");
    rd_ld(10'h011, "R11");
    rd_hold("R11");
    // R10 asynchronous output enable
    cyc(1, 1, 1, 0, 1, 0, 1, 1, '1, '0, '0, 1, 0, "R10");
    cyc(1, 1, 1, 0, 1, 0, 1, 1, '1, '0, '0, 1, 0, "R10");
    rd_hold("R10");
    rd_hold("R10");
    // R5 interleaved order, changed while deselected
    cyc(0, 1, 1, 0, 0, 0, 1, 1, '1, '0, '0, 0, 0, "R5");
    order_ilv = 1;
    rd_ld(10'h011, "R5");
    rd_adv("R5");
    rd_adv("R5");
    rd_adv("R5");
    rd_ld(10'h012, "R5");
    rd_adv("R5");
    rd_adv("R5");
    rd_adv("R5");
    cyc(0, 1, 1, 0, 0, 0, 1, 1, '1, '0, '0, 0, 0, "R2");
    cyc(0, 1, 1, 0, 0, 0, 1, 1, '1, '0, '0, 0, 0, "R2");
    @(negedge clk);
    #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule